// File: doc/BRIEF.md
# Polled Byte Transfer Controller

This block sits between a host bus and a simple byte-wide device port. The host sees four 32-bit registers: control, status, received data and transmit data. To move a byte, the host first polls the status word until busy reads 0. For an outbound transfer it loads the byte into the transmit register. It then writes the control word with the direction bit and the go bit set. From that point the controller owns the command. It raises busy, offers the byte (or a request for one) on the device port, and waits for the device to accept it.

When the device answers, the controller drops busy and clears both the go bit and the error flag. The host never has to clear any of these itself. An inbound byte lands in the received-data register and raises a data-available flag, which a host read of that register clears again. If the device stays silent for a configurable number of cycles, the controller gives up and raises a sticky error. That error remains set until the next command is accepted. Each command moves exactly one byte. A longer transfer repeats the whole poll, load and go sequence.

Top module: `pdc_top`

## Requirements
- R1: Word index bus_addr_i[3:2] selects the register: 0 control (bit 0 go, bit 1 direction, 1 = write to device), 1 status (bit 0 busy, bit 1 error, bit 2 data available), 2 received byte, 3 transmit byte. Data bytes sit in bits [7:0], and all other read bits are 0.
- R2: The active-low asynchronous reset clears every register bit to zero, returns the controller to idle and drops dev_valid_o at once.
- R3: A control write with bit 0 set while idle is accepted at that clock edge. From the next cycle, busy and go read 1, dev_valid_o is 1 and dev_write_o equals the written direction bit.
- R4: During an outbound transfer, dev_wdata_o carries the transmit byte the host loaded before the command.
- R5: A cycle with dev_valid_o and dev_ready_i both high completes the transfer. From the next cycle, busy, go and error all read 0 and dev_valid_o is 0.
- R6: On an inbound completion, dev_rdata_i is stored in the received-byte register and data available reads 1.
- R7: A host read of the received-byte register clears data available, unless a new inbound completion happens in the same cycle.
- R8: While busy, host writes to the control and transmit registers are ignored. No second command starts, and the direction and transmit byte stay unchanged.
- R9: If dev_ready_i stays low for TIMEOUT_CYCLES cycles of a transfer, the controller abandons it. Busy and go clear, error reads 1, and the received-byte register and data available are untouched.
- R10: The error flag stays set until the next accepted command, which clears it in the same edge that raises busy.
- R11: dev_valid_o stays low after a completion or timeout until a new command is accepted, so each command moves exactly one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Host access strobe for this cycle |
| bus_we_i | input | 1 | 1 = host write, 0 = host read |
| bus_addr_i | input | ADDR_W | Host byte address; word index in bits [3:2], upper bits must be 0 |
| bus_wdata_i | input | BUS_W | Host write data |
| bus_rdata_o | output | BUS_W | Read data for the addressed register (combinational) |
| dev_valid_o | output | 1 | A transfer is pending on the device port |
| dev_write_o | output | 1 | Direction of the pending transfer, 1 = to device |
| dev_wdata_o | output | DATA_W | Byte offered to the device |
| dev_ready_i | input | 1 | Device completes the pending transfer this cycle |
| dev_rdata_i | input | DATA_W | Byte returned by the device on an inbound completion |

## Verification
The bench builds the controller with TIMEOUT_CYCLES set to 6 rather than 16. This puts both sides of the timeout edge within a few cycles. A device answer after five idle cycles still completes, while six idle cycles lead to an abandon. With this setting, timeouts can also be chained with successful transfers to show that a sticky error is cleared by the next command. The byte width stays at 8 and the bus width at 32, so the test also covers the zero upper bits of every read word and the ignored upper bits of host writes.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  // word indices, decoded from address bits [3:2]
  localparam int unsigned WORD_LSB  = 2;
  localparam int unsigned W_CTRL    = 0;
  localparam int unsigned W_STAT    = 1;
  localparam int unsigned W_RXD     = 2;
  localparam int unsigned W_TXD     = 3;
  // control bits
  localparam int unsigned CTRL_GO   = 0;
  localparam int unsigned CTRL_WR   = 1;
  // status bits
  localparam int unsigned ST_BUSY   = 0;
  localparam int unsigned ST_ERR    = 1;
  localparam int unsigned ST_AVAIL  = 2;

  typedef enum logic {
    XS_IDLE = 1'b0,
    XS_XFER = 1'b1
  } xfer_state_e;
endpackage

// File: rtl/pdc_fsm.sv
module pdc_fsm
  import pdc_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 16,
  localparam int unsigned CNT_W = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic dev_ready_i,
  output logic busy_o,
  output logic go_o,
  output logic err_o,
  output logic done_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  xfer_state_e      state_q;
  logic [CNT_W-1:0] wait_q;
  logic             go_q, err_q;
  logic             expire_w;

  assign busy_o   = (state_q == XS_XFER);
  assign done_o   = busy_o && dev_ready_i;
  assign expire_w = busy_o && !dev_ready_i && (wait_q == LAST);
  assign go_o     = go_q;
  assign err_o    = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= XS_IDLE;
      wait_q  <= '0;
      go_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        XS_IDLE: begin
          if (start_i) begin
            state_q <= XS_XFER;
            wait_q  <= '0;
            go_q    <= 1'b1;
            err_q   <= 1'b0;
          end
        end
        XS_XFER: begin
          if (dev_ready_i) begin
            state_q <= XS_IDLE;
            go_q    <= 1'b0;
            err_q   <= 1'b0;
          end else if (expire_w) begin
            state_q <= XS_IDLE;
            go_q    <= 1'b0;
            err_q   <= 1'b1;
          end else begin
            wait_q  <= wait_q + 1'b1;
          end
        end
        default: state_q <= XS_IDLE;
      endcase
    end
  end

  p_start_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o && go_o && !err_o);
  p_done_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o && !go_o && !err_o);
  p_no_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !start_i);
  p_timeout_err_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_w |=> err_o && !busy_o && !go_o);
  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !start_i |=> err_o);
  p_one_shot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> !busy_o);
endmodule

// File: rtl/pdc_regs.sv
module pdc_regs
  import pdc_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  input  logic              busy_i,
  input  logic              go_i,
  input  logic              err_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  output logic              start_o,
  output logic              dir_o,
  output logic [DATA_W-1:0] tx_byte_o
);
  localparam int unsigned PAD_W = BUS_W - DATA_W;

  logic              dir_q, avail_q;
  logic [DATA_W-1:0] txd_q, rxd_q;
  logic [1:0]        word_w;
  logic              hit_w, wr_w, wr_ctrl_w, wr_txd_w, rd_rxd_w, rx_load_w;
  logic              unused_w;

  assign word_w    = bus_addr_i[WORD_LSB +: 2];
  assign hit_w     = bus_sel_i && ((bus_addr_i >> 4) == '0);
  assign wr_w      = hit_w && bus_we_i && !busy_i;
  assign wr_ctrl_w = wr_w && (word_w == 2'(W_CTRL));
  assign wr_txd_w  = wr_w && (word_w == 2'(W_TXD));
  assign rd_rxd_w  = hit_w && !bus_we_i && (word_w == 2'(W_RXD));
  assign rx_load_w = done_i && !dir_q;
  assign start_o   = wr_ctrl_w && bus_wdata_i[CTRL_GO];
  assign unused_w  = ^{bus_addr_i[1:0], bus_wdata_i[BUS_W-1:DATA_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= 1'b0;
      txd_q   <= '0;
      rxd_q   <= '0;
      avail_q <= 1'b0;
    end else begin
      if (wr_ctrl_w) dir_q <= bus_wdata_i[CTRL_WR];
      if (wr_txd_w)  txd_q <= bus_wdata_i[DATA_W-1:0];
      if (rx_load_w) begin
        rxd_q   <= rx_byte_i;
        avail_q <= 1'b1;
      end else if (rd_rxd_w) begin
        avail_q <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    unique case (word_w)
      2'(W_CTRL): begin
        bus_rdata_o[CTRL_GO] = go_i;
        bus_rdata_o[CTRL_WR] = dir_q;
      end
      2'(W_STAT): begin
        bus_rdata_o[ST_BUSY]  = busy_i;
        bus_rdata_o[ST_ERR]   = err_i;
        bus_rdata_o[ST_AVAIL] = avail_q;
      end
      2'(W_RXD):  bus_rdata_o = {{PAD_W{1'b0}}, rxd_q};
      default:    bus_rdata_o = {{PAD_W{1'b0}}, txd_q};
    endcase
  end

  assign dir_o     = dir_q;
  assign tx_byte_o = txd_q;

  p_rx_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_load_w |=> avail_q && (rxd_q == $past(rx_byte_i)));
  p_avail_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_rxd_w && !rx_load_w |=> !avail_q);
  p_txd_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(txd_q) && $stable(dir_q));
endmodule

// File: rtl/pdc_top.sv
module pdc_top
  import pdc_pkg::*;
#(
  parameter int unsigned ADDR_W         = 4,
  parameter int unsigned BUS_W          = 32,
  parameter int unsigned DATA_W         = 8,
  parameter int unsigned TIMEOUT_CYCLES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  output logic              dev_valid_o,
  output logic              dev_write_o,
  output logic [DATA_W-1:0] dev_wdata_o,
  input  logic              dev_ready_i,
  input  logic [DATA_W-1:0] dev_rdata_i
);
  logic busy_w, go_w, err_w, done_w, start_w, dir_w;
  logic [DATA_W-1:0] tx_byte_w;

  pdc_regs #(
    .ADDR_W (ADDR_W),
    .BUS_W  (BUS_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_sel_i   (bus_sel_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .busy_i      (busy_w),
    .go_i        (go_w),
    .err_i       (err_w),
    .done_i      (done_w),
    .rx_byte_i   (dev_rdata_i),
    .start_o     (start_w),
    .dir_o       (dir_w),
    .tx_byte_o   (tx_byte_w)
  );

  pdc_fsm #(
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_w),
    .dev_ready_i (dev_ready_i),
    .busy_o      (busy_w),
    .go_o        (go_w),
    .err_o       (err_w),
    .done_o      (done_w)
  );

  assign dev_valid_o = busy_w;
  assign dev_write_o = dir_w;
  assign dev_wdata_o = tx_byte_w;

  p_rst_idle_r2: assert property (@(posedge clk_i)
    !rst_ni |-> !dev_valid_o);
  p_valid_dir_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_valid_o && !dev_ready_i |=> $stable(dev_write_o) && $stable(dev_wdata_o));
endmodule

// File: tb/sim_pdc_top.sv
module sim_pdc_top;
  localparam int CLK_PERIOD = 10;
  localparam int TO         = 6;
  localparam int NVEC       = 9;

  // entry: {direction (1 = to device), byte, device latency in cycles}
  localparam logic [12:0] VECS [NVEC] = '{
    {1'b1, 8'hA5, 4'd0}, {1'b0, 8'h3C, 4'd0}, {1'b1, 8'hFF, 4'd2},
    {1'b0, 8'h81, 4'd3}, {1'b1, 8'h00, 4'd5}, {1'b0, 8'h5A, 4'd5},
    {1'b1, 8'h77, 4'd6}, {1'b0, 8'hC3, 4'd9}, {1'b1, 8'h42, 4'd1}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        dv, dw, dready = 1'b0;
  logic [7:0]  dwdata, drdata = '0;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pdc_top #(.TIMEOUT_CYCLES(TO)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .dev_valid_o(dv), .dev_write_o(dw), .dev_wdata_o(dwdata),
    .dev_ready_i(dready), .dev_rdata_i(drdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    sel = 1'b0;
  endtask

  // look at a register without a bus strobe: no side effect
  task automatic peek(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse_ready(input logic [7:0] b);
    dready = 1'b1; drdata = b;
    @(negedge clk);
    dready = 1'b0; drdata = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R11 act=%h exp=%h", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [7:0]  exp_rxd;
    exp_rxd = '0;
    repeat (3) @(negedge clk);
    chk("R2 valid in reset", 32'(dv), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      peek(4'(a * 4), r);
      chk("R2 reset register", r, 0);
    end

    // R1: upper bits of a write are dropped, read back as zero
    bus_wr(4'hC, 32'hFFFF_FF12);
    peek(4'hC, r); chk("R1 txd readback", r, 32'h12);
    bus_wr(4'h0, 32'h2);
    peek(4'h0, r); chk("R1 ctrl dir only", r, 32'h2);
    chk("R1 no start without go", 32'(dv), 0);

    for (int i = 0; i < NVEC; i++) begin
      logic       dir;
      logic [7:0] b;
      int         lat;
      bit         ok;
      dir = VECS[i][12]; b = VECS[i][11:4]; lat = int'(VECS[i][3:0]);
      ok  = (lat < TO);
      if (dir) bus_wr(4'hC, {24'h0, b});
      bus_wr(4'h0, {30'h0, dir, 1'b1});
      chk("R3 valid", 32'(dv), 1);
      chk("R3 direction", 32'(dw), 32'(dir));
      peek(4'h4, r); chk("R3 R10 busy set error clear", r & 32'h3, 32'h1);
      if (dir) chk("R4 outbound byte", 32'(dwdata), 32'(b));
      repeat (lat) @(negedge clk);
      if (ok) pulse_ready(b);
      else @(negedge clk);
      if (ok && !dir) exp_rxd = b;
      peek(4'h4, r);
      chk(ok ? "R5 R6 status after done" : "R9 status after timeout", r,
          {29'h0, (ok && !dir), !ok, 1'b0});
      peek(4'h0, r); chk("R5 go cleared", r, {30'h0, dir, 1'b0});
      chk("R11 valid dropped", 32'(dv), 0);
      bus_rd(4'h8, r); chk("R6 R9 received byte", r, 32'(exp_rxd));
      peek(4'h4, r); chk("R7 avail cleared by read", r & 32'h4, 0);
    end

    // R8: writes while busy are ignored
    bus_wr(4'hC, 32'h99);
    bus_wr(4'h0, 32'h3);
    bus_wr(4'h0, 32'h1);
    bus_wr(4'hC, 32'h55);
    peek(4'h0, r); chk("R8 ctrl unchanged while busy", r, 32'h3);
    chk("R8 outbound byte held", 32'(dwdata), 32'h99);
    pulse_ready(8'h00);
    peek(4'hC, r); chk("R8 txd unchanged", r, 32'h99);
    for (int k = 0; k < 3; k++) begin
      chk("R11 single transfer", 32'(dv), 0);
      @(negedge clk);
    end

    // R9 R10: sticky error, then cleared by next command
    bus_wr(4'h0, 32'h1);
    repeat (TO + 2) @(negedge clk);
    peek(4'h4, r); chk("R9 timeout error", r, 32'h2);
    repeat (5) @(negedge clk);
    peek(4'h4, r); chk("R10 error sticky", r, 32'h2);
    bus_wr(4'h0, 32'h1);
    peek(4'h4, r); chk("R10 new command clears error", r, 32'h1);
    pulse_ready(8'h6E);
    peek(4'h4, r); chk("R6 avail set", r, 32'h4);
    bus_rd(4'h8, r); chk("R6 rx byte", r, 32'h6E);

    // R2: asynchronous reset mid-transfer
    bus_wr(4'hC, 32'h3A);
    bus_wr(4'h0, 32'h3);
    @(negedge clk);
    rst_ni = 1'b0;
    #1 chk("R2 async reset valid", 32'(dv), 0);
    for (int a = 0; a < 4; a++) begin
      peek(4'(a * 4), r);
      chk("R2 async reset register", r, 0);
    end
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R2 idle after reset", 32'(dv), 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule